// File: doc/BRIEF.md
# Serial Byte Receiver with 24-bit Word Packing

This block receives asynchronous serial frames of one start bit, eight data bits and one stop bit, with no parity. It takes the serial line through a two-flop synchroniser and oversamples it sixteen times per bit. A falling edge counts as a start bit only if the line is still low at the middle of that bit. Each data bit is sampled at its centre, least significant bit first. A byte is kept only when its stop bit reads high. A frame whose stop bit reads low is dropped, raises a one-cycle error pulse, and the receiver then waits for the line to return high before it looks for another start.

Accepted bytes are gathered in groups of three into a 24-bit word for a memory write port. The first byte of a group lands in the top byte of the word. When the third byte arrives, the word is presented together with a single-cycle write strobe. A static select input sets the line rate to 19200 or 9600 baud; the divider for the slower rate is twice the divider for the faster one. If the line stays idle for a set time (ten seconds at the nominal clock), any partly built word is thrown away and a timeout flag is raised. The flag stays high until the next start bit is confirmed.

Top module: `uart_word_rx`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `word_data` is zero and `word_we`, `frame_err` and `timeout_flag` are low.
- R2: Data bits arrive least significant bit first. Three accepted bytes form one word, with the first in bits [23:16], the second in [15:8] and the third in [7:0]. `word_we` is high for exactly one cycle per word.
- R3: With `baud_sel`=1 a bit lasts 16*DIV_FAST clock cycles (19200 baud). With `baud_sel`=0 a bit lasts 32*DIV_FAST cycles (9600 baud).
- R4: A low pulse that has ended before the middle of the start bit produces no byte, no error and no change to word assembly.
- R5: A frame whose stop bit samples low gives a one-cycle `frame_err` pulse. Its byte is not added to the word, and the bytes already held are kept.
- R6: After TIMEOUT_CLKS cycles with the receiver idle, any partial word is discarded and `timeout_flag` goes high. It returns low when the next start bit is confirmed.
- R7: `word_data` changes only in cycles where `word_we` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_sel | input | 1 | 1 selects 19200 baud, 0 selects 9600 baud |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| word_data | output | 24 | Last assembled word |
| word_we | output | 1 | One-cycle write strobe for `word_data` |
| frame_err | output | 1 | One-cycle pulse on a frame whose stop bit is low |
| timeout_flag | output | 1 | Set on idle timeout, cleared by the next start bit |

## Verification
A wrong byte counter or a slipped shift register shows up at the write port on the very next strobe. The word arrives with its bytes rotated or missing, or it arrives one frame early or late. That is why every word the bench sends is checked byte for byte. Errors in the oversampling counter or the divider show as bits read from the wrong place, so words come out corrupted within the first frame; bit patterns chosen to be asymmetric make that visible. A lost frame-error or timeout path shows only on the next word after the fault, which is therefore checked right after each such event.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

    localparam int OVERSAMPLE = 16;
    localparam int MID_TICK   = OVERSAMPLE / 2 - 1;
    localparam int LAST_TICK  = OVERSAMPLE - 1;
    localparam int DATA_BITS  = 8;
    localparam int WORD_BYTES = 3;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_t;

    typedef struct packed {
        logic                 start;
        logic                 valid;
        logic                 err;
        logic [DATA_BITS-1:0] data;
    } frame_evt_t;

    function automatic logic [23:0] push_byte(input logic [23:0] acc,
                                              input logic [7:0]  b);
        return {acc[15:0], b};
    endfunction

endpackage

// File: rtl/uwr_sync.sv
module uwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/uwr_tick.sv
module uwr_tick #(
    parameter int DIV_FAST = 163
) (
    input  logic clk,
    input  logic rst,
    input  logic baud_sel,
    output logic tick
);
    localparam int DIV_SLOW = 2 * DIV_FAST;
    localparam int CW       = $clog2(DIV_SLOW + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit = baud_sel ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= limit) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uwr_frame.sv
module uwr_frame
    import uwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx,
    output frame_evt_t evt,
    output logic       busy
);
    rx_state_t      state;
    logic [3:0]     os_cnt;
    logic [2:0]     bit_idx;
    logic [7:0]     shreg;

    assign busy = (state != RX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            os_cnt  <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            evt     <= '0;
        end else begin
            evt.start <= 1'b0;
            evt.valid <= 1'b0;
            evt.err   <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (tick && !rx) begin
                        state  <= RX_START;
                        os_cnt <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (os_cnt == 4'(MID_TICK)) begin
                            os_cnt <= '0;
                            if (!rx) begin
                                state     <= RX_DATA;
                                bit_idx   <= '0;
                                evt.start <= 1'b1;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (os_cnt == 4'(LAST_TICK)) begin
                            os_cnt <= '0;
                            shreg  <= {rx, shreg[7:1]};
                            if (bit_idx == 3'(DATA_BITS - 1)) state <= RX_STOP;
                            else bit_idx <= bit_idx + 1'b1;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (os_cnt == 4'(LAST_TICK)) begin
                            os_cnt <= '0;
                            if (rx) begin
                                evt.valid <= 1'b1;
                                evt.data  <= shreg;
                                state     <= RX_IDLE;
                            end else begin
                                evt.err <= 1'b1;
                                state   <= RX_HOLD;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_HOLD: begin
                    if (rx) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uwr_pack.sv
module uwr_pack
    import uwr_pkg::*;
#(
    parameter int TIMEOUT_CLKS = 500_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  frame_evt_t  evt,
    input  logic        busy,
    output logic [23:0] word_data,
    output logic        word_we,
    output logic        timeout_flag
);
    localparam int TW = $clog2(TIMEOUT_CLKS + 1);

    logic [TW-1:0] timer;
    logic [1:0]    byte_cnt;
    logic [23:0]   acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            timer        <= '0;
            byte_cnt     <= '0;
            acc          <= '0;
            word_data    <= '0;
            word_we      <= 1'b0;
            timeout_flag <= 1'b0;
        end else begin
            word_we <= 1'b0;
            if (evt.start) begin
                timer        <= '0;
                timeout_flag <= 1'b0;
            end else if (busy) begin
                timer <= '0;
            end else if (timer == TW'(TIMEOUT_CLKS - 1)) begin
                timeout_flag <= 1'b1;
                byte_cnt     <= '0;
                acc          <= '0;
            end else begin
                timer <= timer + 1'b1;
            end

            if (evt.valid) begin
                if (byte_cnt == 2'(WORD_BYTES - 1)) begin
                    word_data <= push_byte(acc, evt.data);
                    word_we   <= 1'b1;
                    byte_cnt  <= '0;
                    acc       <= '0;
                end else begin
                    acc      <= push_byte(acc, evt.data);
                    byte_cnt <= byte_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_word_rx.sv
module uart_word_rx
    import uwr_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int DIV_FAST     = (CLK_HZ + 19200 * 8) / (19200 * OVERSAMPLE),
    parameter int TIMEOUT_CLKS = CLK_HZ * 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        baud_sel,
    input  logic        rx_in,
    output logic [23:0] word_data,
    output logic        word_we,
    output logic        frame_err,
    output logic        timeout_flag
);
    logic       rx_s;
    logic       tick;
    logic       busy;
    frame_evt_t evt;

    uwr_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d_async(rx_in), .d_sync(rx_s)
    );

    uwr_tick #(.DIV_FAST(DIV_FAST)) u_tick (
        .clk(clk), .rst(rst), .baud_sel(baud_sel), .tick(tick)
    );

    uwr_frame u_frame (
        .clk(clk), .rst(rst), .tick(tick), .rx(rx_s), .evt(evt), .busy(busy)
    );

    uwr_pack #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_pack (
        .clk(clk), .rst(rst), .evt(evt), .busy(busy),
        .word_data(word_data), .word_we(word_we), .timeout_flag(timeout_flag)
    );

    assign frame_err = evt.err;
endmodule

// File: rtl/uwr_checker.sv
module uwr_checker (
    input logic        clk,
    input logic        rst,
    input logic [23:0] word_data,
    input logic        word_we,
    input logic        frame_err,
    input logic        timeout_flag
);
    assert_we_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        word_we |=> !word_we);

    assert_err_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    assert_err_no_we_R5: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !word_we);

    assert_we_after_start_R6: assert property (@(posedge clk) disable iff (rst)
        word_we |-> !timeout_flag);

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !word_we |-> $stable(word_data));
endmodule

bind uart_word_rx uwr_checker u_chk (
    .clk(clk), .rst(rst), .word_data(word_data), .word_we(word_we),
    .frame_err(frame_err), .timeout_flag(timeout_flag)
);

// File: tb/uart_word_rx_bench.sv
module uart_word_rx_bench;
    localparam int DIV = 4;
    localparam int TO  = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        baud_sel = 1'b1;
    logic        rx_in = 1'b1;
    logic [23:0] word_data;
    logic        word_we;
    logic        frame_err;
    logic        timeout_flag;

    int errors = 0;
    int checks = 0;
    int we_cnt = 0;
    int err_cnt = 0;
    logic [23:0] cap = '0;

    always #2.5 clk = ~clk;

    uart_word_rx #(.CLK_HZ(1_000_000), .DIV_FAST(DIV), .TIMEOUT_CLKS(TO)) u_uart_word_rx (
        .clk(clk), .rst(rst), .baud_sel(baud_sel), .rx_in(rx_in),
        .word_data(word_data), .word_we(word_we),
        .frame_err(frame_err), .timeout_flag(timeout_flag)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (word_we) begin
                we_cnt++;
                cap = word_data;
            end
            if (frame_err) err_cnt++;
        end
    end

    // {baud_sel, word}
    localparam logic [24:0] VEC [0:5] = '{
        {1'b1, 24'h123456},
        {1'b1, 24'h0180FF},
        {1'b0, 24'hA55AC3},
        {1'b0, 24'h000001},
        {1'b1, 24'h800000},
        {1'b0, 24'h7E3C81}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int bit_len();
        return 16 * DIV * (baud_sel ? 1 : 2);
    endfunction

    task automatic send_byte(input logic [7:0] b, input logic stop_ok);
        rx_in = 1'b0;
        repeat (bit_len()) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_in = b[i];
            repeat (bit_len()) @(negedge clk);
        end
        rx_in = stop_ok;
        repeat (bit_len()) @(negedge clk);
        rx_in = 1'b1;
        repeat (bit_len()) @(negedge clk);
    endtask

    task automatic send_word(input logic [23:0] w);
        send_byte(w[23:16], 1'b1);
        send_byte(w[15:8], 1'b1);
        send_byte(w[7:0], 1'b1);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base_we;
        int base_err;
        logic [23:0] held;

        // R1: reset state, during and right after reset
        repeat (5) @(negedge clk);
        chk("R1 word_data", 32'(word_data), 32'h0);
        chk("R1 word_we", 32'(word_we), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 frame_err", 32'(frame_err), 32'h0);
        chk("R1 timeout_flag", 32'(timeout_flag), 32'h0);

        // R2 / R3: table of words at both line rates
        for (int i = 0; i < 6; i++) begin
            baud_sel = VEC[i][24];
            repeat (4) @(negedge clk);
            base_we = we_cnt;
            send_word(VEC[i][23:0]);
            chk("R2 one strobe per word", 32'(we_cnt - base_we), 32'd1);
            chk(baud_sel ? "R3 word at 19200" : "R3 word at 9600", 32'(cap), 32'(VEC[i][23:0]));
        end

        // R5 / R7: bad stop bit is dropped, held bytes kept
        baud_sel = 1'b1;
        base_we = we_cnt;
        base_err = err_cnt;
        held = word_data;
        send_byte(8'h5A, 1'b1);
        send_byte(8'hC3, 1'b0);
        repeat (20) @(negedge clk);
        chk("R5 error pulse count", 32'(err_cnt - base_err), 32'd1);
        chk("R7 word_data held", 32'(word_data), 32'(held));
        send_byte(8'h21, 1'b1);
        send_byte(8'h43, 1'b1);
        repeat (20) @(negedge clk);
        chk("R5 strobe count", 32'(we_cnt - base_we), 32'd1);
        chk("R5 bad byte skipped", 32'(cap), 32'h5A2143);

        // R4: short low glitch ignored
        base_we = we_cnt;
        base_err = err_cnt;
        rx_in = 1'b0;
        repeat (12) @(negedge clk);
        rx_in = 1'b1;
        repeat (3 * bit_len()) @(negedge clk);
        chk("R4 no error from glitch", 32'(err_cnt - base_err), 32'd0);
        send_word(24'h9ABCDE);
        chk("R4 strobe count", 32'(we_cnt - base_we), 32'd1);
        chk("R4 word intact", 32'(cap), 32'h9ABCDE);

        // R6: timeout clears the partial word
        base_we = we_cnt;
        send_byte(8'hEE, 1'b1);
        repeat (TO + 500) @(negedge clk);
        chk("R6 flag raised", 32'(timeout_flag), 32'h1);
        send_word(24'h112233);
        chk("R6 flag cleared", 32'(timeout_flag), 32'h0);
        chk("R6 strobe count", 32'(we_cnt - base_we), 32'd1);
        chk("R6 partial byte dropped", 32'(cap), 32'h112233);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule